// File: doc/BRIEF.md
# Double-Buffered Codec Sample Exchange

This block connects a voice-band converter's sample engine to a serial shifter. It keeps two holding registers. One carries converter-to-host samples (A/D). The other carries host-to-converter samples (D/A). Because of these registers, the codec side and the serial side can each move a word in any cycle without waiting for the other.

On every sample strobe, the codec side captures a fresh A/D word into its holding register. In the same cycle it moves the pending D/A word into the converter output register. It also raises a status flag, which tells the serial side that a new frame is ready. The serial side lowers the flag in either of two ways: by copying the A/D holding register into its output shifter, or by writing a new word into the D/A holding register.

A control bit named `active` gates all codec-side exchanges. Serial-side writes are accepted at all times, including while `active` is 0. In the target system the strobe arrives once every 125 cycles of a 1 MHz oversampling clock, which gives an 8 kHz sample rate.

Top module: `codec_xchg`

## Requirements
- R1: After synchronous reset, `adc_hold`, `dac_word` and `status` are 0, and the D/A holding register is 0. A strobe taken straight after reset therefore drives `dac_word` to 0.
- R2: A cycle with `smp_stb`=1 and `active`=1 is called a fire. On the edge after a fire, `adc_hold` equals the `adc_word` that was present during the fire.
- R3: On the edge after a fire, `dac_word` equals the D/A holding register as it stood before that edge. If no serial write happens between two fires, the same D/A word is sent again.
- R4: `status` is 1 on the edge after any fire.
- R5: In a cycle with no fire, `srl_take`=1 or `srl_put`=1 makes `status` 0 on the next edge.
- R6: When a fire and a serial clear fall in the same cycle, `status` is 1 afterwards, because the set wins.
- R7: While `active`=0, `smp_stb` has no effect on `adc_hold`, `dac_word` or `status`.
- R8: `srl_put`=1 loads `srl_word` into the D/A holding register whatever the value of `active`. The stored word reaches `dac_word` on the next fire.
- R9: If `srl_put` coincides with a fire, `dac_word` takes the previously held word. The newly written word is delivered on the following fire.
- R10: `adc_hold` and `dac_word` change only on the edge after a fire. Serial activity alone never alters them.
- R11: `status` never rises except on the edge after a fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle sample-period strobe from the codec engine |
| active | input | 1 | Control bit that enables codec-side exchanges |
| adc_word | input | 16 | New A/D sample offered on the strobe |
| srl_take | input | 1 | Serial side copies `adc_hold` into its output shifter |
| srl_put | input | 1 | Serial side writes `srl_word` into the D/A holding register |
| srl_word | input | 16 | Word from the serial input shifter |
| dac_word | output | 16 | Sample presented to the D/A converter |
| adc_hold | output | 16 | A/D holding register contents |
| status | output | 1 | New-frame flag for the serial side |

## Verification
The checker tests four things on every cycle:
- the flag's set, clear and set-wins priority;
- the capture of the A/D word on a fire;
- the stability of both sample outputs in cycles without a fire;
- the absence of any rise of the flag without a fire.

The bench covers the behaviours that only show up across several cycles. These are:
- the resend of a D/A word that was not refreshed;
- delivery of a word that was written while the block was inactive;
- the one-sample delay of a word written in the same cycle as a fire;
- the reset contents of the hidden D/A holding register.

The bench sweeps all sixteen combinations of strobe, active, take and put from a primed state. It also runs a strobe stream with the real 125-cycle spacing.

// File: rtl/codec_xchg_pkg.sv
package codec_xchg_pkg;

    localparam int unsigned SAMPLE_W_DEF = 16;

    // Next-state decision for the status flag
    typedef enum logic [1:0] {
        FLAG_KEEP = 2'd0,
        FLAG_SET  = 2'd1,
        FLAG_CLR  = 2'd2
    } flag_op_e;

    // Decoded exchange events of one cycle
    typedef struct packed {
        logic codec_fire;   // codec-side exchange takes place
        logic dac_write;    // serial side writes the D/A holding register
        logic adc_read;     // serial side reads the A/D holding register
        logic srl_clear;    // any serial-side exchange
    } xchg_ev_t;

    function automatic xchg_ev_t decode_events(
        input logic stb,
        input logic act,
        input logic take,
        input logic put
    );
        xchg_ev_t ev;
        ev.codec_fire = stb & act;
        ev.dac_write  = put;
        ev.adc_read   = take;
        ev.srl_clear  = take | put;
        return ev;
    endfunction

    // The codec-side set has priority over a serial-side clear
    function automatic flag_op_e flag_decide(input xchg_ev_t ev);
        if (ev.codec_fire)
            return FLAG_SET;
        else if (ev.srl_clear)
            return FLAG_CLR;
        else
            return FLAG_KEEP;
    endfunction

endpackage

// File: rtl/codec_xchg_evdec.sv
module codec_xchg_evdec
    import codec_xchg_pkg::*;
(
    input  logic     smp_stb,
    input  logic     active,
    input  logic     srl_take,
    input  logic     srl_put,
    output xchg_ev_t ev
);
    always_comb begin
        ev = decode_events(smp_stb, active, srl_take, srl_put);
    end
endmodule

// File: rtl/codec_xchg_adc_reg.sv
module codec_xchg_adc_reg
    import codec_xchg_pkg::*;
#(
    parameter int unsigned W = SAMPLE_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  xchg_ev_t     ev,
    input  logic [W-1:0] sample_in,
    output logic [W-1:0] hold_q
);
    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (ev.codec_fire)
            hold_q <= sample_in;
    end
endmodule

// File: rtl/codec_xchg_dac_path.sv
module codec_xchg_dac_path
    import codec_xchg_pkg::*;
#(
    parameter int unsigned W = SAMPLE_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  xchg_ev_t     ev,
    input  logic [W-1:0] srl_in,
    output logic [W-1:0] conv_q
);
    logic [W-1:0] hold_q;

    // Holding stage: written by the serial side at any time
    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (ev.dac_write)
            hold_q <= srl_in;
    end

    // Converter stage: empties the holding stage on a fire; an
    // unrefreshed holding value is simply sent again
    always_ff @(posedge clk) begin
        if (rst)
            conv_q <= '0;
        else if (ev.codec_fire)
            conv_q <= hold_q;
    end
endmodule

// File: rtl/codec_xchg_flag.sv
module codec_xchg_flag
    import codec_xchg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  xchg_ev_t ev,
    output logic     flag_q
);
    flag_op_e op;

    always_comb begin
        op = flag_decide(ev);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            unique case (op)
                FLAG_SET: flag_q <= 1'b1;
                FLAG_CLR: flag_q <= 1'b0;
                default:  flag_q <= flag_q;
            endcase
        end
    end
endmodule

// File: rtl/codec_xchg.sv
module codec_xchg
    import codec_xchg_pkg::*;
#(
    parameter int unsigned W = SAMPLE_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         smp_stb,
    input  logic         active,
    input  logic [W-1:0] adc_word,
    input  logic         srl_take,
    input  logic         srl_put,
    input  logic [W-1:0] srl_word,
    output logic [W-1:0] dac_word,
    output logic [W-1:0] adc_hold,
    output logic         status
);
    xchg_ev_t ev;

    codec_xchg_evdec u_evdec (
        .smp_stb  (smp_stb),
        .active   (active),
        .srl_take (srl_take),
        .srl_put  (srl_put),
        .ev       (ev)
    );

    codec_xchg_adc_reg #(.W(W)) u_adc (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .sample_in (adc_word),
        .hold_q    (adc_hold)
    );

    codec_xchg_dac_path #(.W(W)) u_dac (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .srl_in (srl_word),
        .conv_q (dac_word)
    );

    codec_xchg_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .flag_q (status)
    );
endmodule

// File: rtl/codec_xchg_chk.sv
module codec_xchg_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         smp_stb,
    input logic         active,
    input logic [W-1:0] adc_word,
    input logic         srl_take,
    input logic         srl_put,
    input logic [W-1:0] dac_word,
    input logic [W-1:0] adc_hold,
    input logic         status
);
    logic fire;
    assign fire = smp_stb & active;

    assert_adc_capture_R2: assert property (@(posedge clk) disable iff (rst)
        fire |=> (adc_hold == $past(adc_word)));

    assert_status_set_R4: assert property (@(posedge clk) disable iff (rst)
        fire |=> status);

    assert_status_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (!fire && (srl_take || srl_put)) |=> !status);

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && (srl_take || srl_put)) |=> status);

    assert_inactive_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (!active) |=> ($stable(adc_hold) && $stable(dac_word)));

    assert_outputs_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (!fire) |=> ($stable(adc_hold) && $stable(dac_word)));

    assert_no_spurious_rise_R11: assert property (@(posedge clk) disable iff (rst)
        (!fire) |=> !$rose(status));
endmodule

bind codec_xchg codec_xchg_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .smp_stb  (smp_stb),
    .active   (active),
    .adc_word (adc_word),
    .srl_take (srl_take),
    .srl_put  (srl_put),
    .dac_word (dac_word),
    .adc_hold (adc_hold),
    .status   (status)
);

// File: tb/codec_xchg_tb.sv
`timescale 1ns/1ps
module codec_xchg_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         smp_stb = 1'b0;
    logic         active = 1'b0;
    logic [W-1:0] adc_word = '0;
    logic         srl_take = 1'b0;
    logic         srl_put = 1'b0;
    logic [W-1:0] srl_word = '0;
    logic [W-1:0] dac_word;
    logic [W-1:0] adc_hold;
    logic         status;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    codec_xchg #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .active(active),
        .adc_word(adc_word), .srl_take(srl_take), .srl_put(srl_put),
        .srl_word(srl_word), .dac_word(dac_word), .adc_hold(adc_hold),
        .status(status)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, return at the next falling edge
    task automatic cyc(input logic stb, input logic act, input logic take,
                       input logic put, input logic [W-1:0] aw,
                       input logic [W-1:0] sw);
        smp_stb = stb; active = act; srl_take = take; srl_put = put;
        adc_word = aw; srl_word = sw;
        @(negedge clk);
        smp_stb = 1'b0; srl_take = 1'b0; srl_put = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 adc_hold reset", int'(adc_hold), 0);
        chk("R1 dac_word reset", int'(dac_word), 0);
        chk("R1 status reset", int'(status), 0);
        // Strobe right after reset: D/A holding register was 0
        cyc(1, 1, 0, 0, 16'h5A5A, 16'h0);
        chk("R1 dac hold reset value", int'(dac_word), 0);
        chk("R2 first capture", int'(adc_hold), 16'h5A5A);
        chk("R4 status after fire", int'(status), 1);

        // Sweep all 16 combinations of stb/active/take/put
        for (int code = 0; code < 16; code++) begin
            logic s, a, t, p;
            logic [W-1:0] d1, d2, pw, qw, nw, rw;
            logic fire;
            s = code[3]; a = code[2]; t = code[1]; p = code[0];
            d1 = W'(16'h1000 + code * 3);
            d2 = W'(16'h2000 + code * 5);
            pw = W'(16'h3000 + code * 7);
            qw = W'(16'h4000 + code * 11);
            nw = W'(16'h5000 + code * 13);
            rw = W'(16'h6000 + code * 17);
            fire = s & a;
            // Prime: store d1, then fire with simultaneous write of d2
            cyc(0, 1, 0, 1, 16'h0, d1);
            cyc(1, 1, 0, 1, pw, d2);
            chk("R9 old word on coincident put", int'(dac_word), int'(d1));
            chk("R6 set wins over put", int'(status), 1);
            // Combination cycle
            cyc(s, a, t, p, qw, nw);
            chk(fire ? "R2 capture in sweep" : "R7 R10 adc_hold kept",
                int'(adc_hold), int'(fire ? qw : pw));
            chk(fire ? "R3 R9 held word sent" : "R7 R10 dac_word kept",
                int'(dac_word), int'(fire ? d2 : d1));
            chk(fire ? ((t | p) ? "R6 set wins" : "R4 status set")
                     : ((t | p) ? "R5 status cleared" : "R11 status kept"),
                int'(status), (fire || !(t | p)) ? 1 : 0);
            // Follow-up fire: put word (even when inactive) is delivered
            cyc(1, 1, 0, 0, rw, 16'h0);
            chk(p ? "R8 put word delivered" : "R3 resend held word",
                int'(dac_word), int'(p ? nw : d2));
            chk("R4 status after follow-up", int'(status), 1);
        end

        // Resend: several fires without serial writes repeat the word
        cyc(0, 1, 0, 1, 16'h0, 16'hBEEF);
        chk("R5 put clears status", int'(status), 0);
        for (int k = 0; k < 3; k++) begin
            cyc(1, 1, 0, 0, W'(16'h0100 + k), 16'h0);
            chk("R3 repeated word", int'(dac_word), 16'hBEEF);
        end
        cyc(0, 1, 1, 0, 16'h0, 16'h0);
        chk("R5 take clears status", int'(status), 0);
        chk("R10 take leaves adc_hold", int'(adc_hold), 16'h0102);

        // Inactive strobes do nothing, even over many periods
        for (int k = 0; k < 4; k++) begin
            cyc(1, 0, 0, 0, 16'hFFFF, 16'h0);
            chk("R7 inactive adc_hold", int'(adc_hold), 16'h0102);
            chk("R7 inactive status", int'(status), 0);
        end

        // Real-rate stream: strobe every 125 cycles, ramp samples
        for (int k = 0; k < 6; k++) begin
            logic [W-1:0] ramp;
            ramp = W'(k * 16'h0123 + 16'h0011);
            cyc(1, 1, 0, 1, ramp, W'(~ramp));
            chk("R2 stream capture", int'(adc_hold), int'(ramp));
            chk("R9 stream dac lag", int'(dac_word),
                k == 0 ? 16'hBEEF : int'(W'(~((k - 1) * 16'h0123 + 16'h0011))));
            for (int i = 0; i < 123; i++) cyc(0, 1, 0, 0, 16'h0, 16'h0);
            chk("R10 stream hold stable", int'(adc_hold), int'(ramp));
            chk("R11 stream status kept", int'(status), 1);
            cyc(0, 1, 1, 0, 16'h0, 16'h0);
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule